// File: doc/BRIEF.md
# Debug channel transmit mailbox

This block is a single-word, 32-bit mailbox that carries data from a processor core out to an external debugger. The core deposits a word with a write strobe, and that same clock edge raises a full flag. The debugger collects the word by reading one register in its debug register window, and the read drops the flag again. The core watches the flag on a status output and waits for it to fall before it sends the next word.

The debugger can also write the data register. When the mailbox is empty, the write simply loads the register. When the mailbox is full, the write destroys the pending word: the register takes a fixed corruption pattern, and a sticky error bit records the event. A debugger write never changes the full flag. Accesses from the debugger to any other offset in the window have no effect. Same-cycle collisions are resolved in favour of the core.

Top module: `dbg_tx_mailbox`

## Requirements
- R1: After an active-low synchronous reset, `coreFull` and `dbgErr` are 0 and the data register holds 0, so an empty read returns 0xFFFF_FFFF.
- R2: A core write strobe loads `coreWrData` and makes `coreFull` 1 from the next clock edge, whatever the flag was before.
- R3: A debugger read at byte offset 0x08C while the flag is 1 returns, in the same cycle, the last word the core stored.
- R4: A debugger read at offset 0x08C while the flag is 0 returns the stored register value XOR 0xFFFF_FFFF, which is a known stand-in for the unspecified value.
- R5: A debugger read at offset 0x08C clears the flag at the clock edge that ends the read, unless a core write occurs in the same cycle.
- R6: A debugger write at offset 0x08C while the flag is 0, with no core write in the same cycle, loads `dbgWrData` into the data register.
- R7: A debugger write at offset 0x08C while the flag is 1 loads 0xDEAD_C0DE into the data register, unless the core writes in the same cycle, and it sets `dbgErr`.
- R8: A debugger write never changes the full flag.
- R9: A debugger read or write at any offset other than 0x08C changes neither the flag, the data register nor `dbgErr`, and the read returns 0.
- R10: When a core write and a debugger read occur in the same cycle, the read returns the old contents, the flag stays 1, and the register holds the new core word.
- R11: When a core write and a debugger write occur in the same cycle, the register takes the core word, and `dbgErr` is set only if the flag was already 1.
- R12: `dbgErr` stays 1 until reset, regardless of later traffic.
- R13: `dbgRdData` is 0 in every cycle without a debugger read at offset 0x08C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| coreWrEn | input | 1 | Core write strobe |
| coreWrData | input | 32 | Word the core deposits |
| coreFull | output | 1 | Full flag, visible to the core |
| dbgAddr | input | 12 | Byte address inside the debug register window |
| dbgRdEn | input | 1 | Debugger read strobe |
| dbgWrEn | input | 1 | Debugger write strobe |
| dbgWrData | input | 32 | Debugger write data |
| dbgRdData | output | 32 | Debugger read data, valid in the cycle of the read |
| dbgErr | output | 1 | Sticky flag that records a debugger write while the mailbox was full |

## Verification
A wrong flag state shows on `coreFull` one edge after the access that caused it. It also changes which branch a following debugger read takes: a word returned inverted, or a real word where the inverted pattern was expected. A wrong data register value cannot hide, because either kind of read exposes it exactly, in the cycle of the read. A missed or spurious error event shows on `dbgErr` one edge later and then persists. A collision resolved the wrong way therefore shows up on the read that follows it.

// File: rtl/dbg_tx_pkg.sv
package dbg_tx_pkg;
  // Strobes that the control sends to the datapath each cycle
  typedef struct packed {
    logic loadCore;     // take the core word
    logic loadDbg;      // take the debugger word
    logic loadCorrupt;  // take the corruption pattern
    logic rdHit;        // a decoded debugger read is in progress
    logic rdFull;       // flag value seen by that read
  } dpStrobes_t;
endpackage

// File: rtl/dbg_tx_ctrl.sv
module dbg_tx_ctrl
  import dbg_tx_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h08C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreWrEn,
  input  logic [ADDR_W-1:0] dbgAddr,
  input  logic              dbgRdEn,
  input  logic              dbgWrEn,
  output logic              fullQ,
  output logic              errQ,
  output dpStrobes_t        strobes
);
  logic addrHit, rdHit, wrHit;

  assign addrHit = (dbgAddr == REG_OFFSET);
  assign rdHit   = dbgRdEn && addrHit;
  assign wrHit   = dbgWrEn && addrHit;

  always_comb begin
    strobes             = '0;
    strobes.loadCore    = coreWrEn;
    strobes.loadDbg     = wrHit && !fullQ && !coreWrEn;
    strobes.loadCorrupt = wrHit && fullQ && !coreWrEn;
    strobes.rdHit       = rdHit;
    strobes.rdFull      = fullQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fullQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      // core deposit wins over a clearing read
      if (coreWrEn)   fullQ <= 1'b1;
      else if (rdHit) fullQ <= 1'b0;
      if (wrHit && fullQ) errQ <= 1'b1;
    end
  end
endmodule

// File: rtl/dbg_tx_datapath.sv
module dbg_tx_datapath
  import dbg_tx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] CORRUPT_PAT = 32'hDEAD_C0DE,
  parameter logic [DATA_W-1:0] EMPTY_MASK  = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [DATA_W-1:0] coreWrData,
  input  logic [DATA_W-1:0] dbgWrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (!rstN)                    dataQ <= '0;
    else if (strobes.loadCore)    dataQ <= coreWrData;
    else if (strobes.loadCorrupt) dataQ <= CORRUPT_PAT;
    else if (strobes.loadDbg)     dataQ <= dbgWrData;
  end

  always_comb begin
    if (!strobes.rdHit)      rdData = '0;
    else if (strobes.rdFull) rdData = dataQ;
    else                     rdData = dataQ ^ EMPTY_MASK;
  end
endmodule

// File: rtl/dbg_tx_mailbox.sv
module dbg_tx_mailbox
  import dbg_tx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET  = 12'h08C,
  parameter logic [DATA_W-1:0] CORRUPT_PAT = 32'hDEAD_C0DE,
  parameter logic [DATA_W-1:0] EMPTY_MASK  = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreWrEn,
  input  logic [DATA_W-1:0] coreWrData,
  output logic              coreFull,
  input  logic [ADDR_W-1:0] dbgAddr,
  input  logic              dbgRdEn,
  input  logic              dbgWrEn,
  input  logic [DATA_W-1:0] dbgWrData,
  output logic [DATA_W-1:0] dbgRdData,
  output logic              dbgErr
);
  dpStrobes_t strobes;
  logic fullQ, errQ;

  dbg_tx_ctrl #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) i_ctrl (
    .clk(clk), .rstN(rstN), .coreWrEn(coreWrEn), .dbgAddr(dbgAddr),
    .dbgRdEn(dbgRdEn), .dbgWrEn(dbgWrEn),
    .fullQ(fullQ), .errQ(errQ), .strobes(strobes)
  );

  dbg_tx_datapath #(.DATA_W(DATA_W), .CORRUPT_PAT(CORRUPT_PAT),
                    .EMPTY_MASK(EMPTY_MASK)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .coreWrData(coreWrData), .dbgWrData(dbgWrData), .rdData(dbgRdData)
  );

  assign coreFull = fullQ;
  assign dbgErr   = errQ;
endmodule

// File: rtl/dbg_tx_mailbox_chk.sv
module dbg_tx_mailbox_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h08C
) (
  input logic              clk,
  input logic              rstN,
  input logic              coreWrEn,
  input logic              coreFull,
  input logic [ADDR_W-1:0] dbgAddr,
  input logic              dbgRdEn,
  input logic              dbgWrEn,
  input logic [DATA_W-1:0] dbgRdData,
  input logic              dbgErr
);
  logic rdHit, wrHit;
  assign rdHit = dbgRdEn && (dbgAddr == REG_OFFSET);
  assign wrHit = dbgWrEn && (dbgAddr == REG_OFFSET);

  p_core_sets_full_r2: assert property (@(posedge clk) disable iff (!rstN)
    coreWrEn |=> coreFull);

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdHit && !coreWrEn) |=> !coreFull);

  p_write_keeps_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dbgWrEn && !rdHit && !coreWrEn) |=> (coreFull == $past(coreFull)));

  p_collide_err_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && coreFull) |=> dbgErr);

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    dbgErr |=> dbgErr);

  p_idle_read_zero_r13: assert property (@(posedge clk) disable iff (!rstN)
    !rdHit |-> (dbgRdData == '0));

  p_read_full_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdHit && coreWrEn) |=> coreFull);
endmodule

bind dbg_tx_mailbox dbg_tx_mailbox_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)
) i_chk (
  .clk(clk), .rstN(rstN), .coreWrEn(coreWrEn), .coreFull(coreFull),
  .dbgAddr(dbgAddr), .dbgRdEn(dbgRdEn), .dbgWrEn(dbgWrEn),
  .dbgRdData(dbgRdData), .dbgErr(dbgErr)
);

// File: tb/test_dbg_tx_mailbox.sv
module test_dbg_tx_mailbox;
  localparam logic [11:0] OFF     = 12'h08C;
  localparam logic [31:0] CORRUPT = 32'hDEAD_C0DE;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        coreWrEn = 1'b0;
  logic [31:0] coreWrData = '0;
  logic        coreFull;
  logic [11:0] dbgAddr = '0;
  logic        dbgRdEn = 1'b0;
  logic        dbgWrEn = 1'b0;
  logic [31:0] dbgWrData = '0;
  logic [31:0] dbgRdData;
  logic        dbgErr;

  int  nTests = 0;
  int  nFail = 0;
  bit  done = 0;

  always #4 clk = ~clk;  // 125 MHz

  dbg_tx_mailbox i_dbg_tx_mailbox (
    .clk(clk), .rstN(rstN), .coreWrEn(coreWrEn), .coreWrData(coreWrData),
    .coreFull(coreFull), .dbgAddr(dbgAddr), .dbgRdEn(dbgRdEn),
    .dbgWrEn(dbgWrEn), .dbgWrData(dbgWrData), .dbgRdData(dbgRdData),
    .dbgErr(dbgErr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle of stimulus; rdv is dbgRdData sampled mid-cycle
  task automatic step(bit cw, logic [31:0] cd, bit rd, bit wr,
                      logic [11:0] addr, logic [31:0] wd,
                      output logic [31:0] rdv);
    @(negedge clk);
    coreWrEn = cw; coreWrData = cd; dbgRdEn = rd; dbgWrEn = wr;
    dbgAddr = addr; dbgWrData = wd;
    #1 rdv = dbgRdData;
    @(posedge clk);
    #1;
    coreWrEn = 0; dbgRdEn = 0; dbgWrEn = 0; dbgAddr = '0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    doReset();
    chk("R1 full after reset", {31'b0, coreFull}, 0);
    chk("R1 err after reset", {31'b0, dbgErr}, 0);
    step(0, 0, 0, 0, OFF, 0, r);
    chk("R13 idle read data", r, 0);
    step(0, 0, 1, 0, OFF, 0, r);
    chk("R1 R4 empty read after reset", r, 32'hFFFF_FFFF);
    chk("R5 flag after empty read", {31'b0, coreFull}, 0);
  endtask

  task automatic t_dbg_write_empty();
    logic [31:0] r;
    step(0, 0, 0, 1, OFF, 32'h1234_5678, r);
    chk("R8 flag after empty write", {31'b0, coreFull}, 0);
    chk("R6 no error on empty write", {31'b0, dbgErr}, 0);
    step(0, 0, 1, 0, OFF, 0, r);
    chk("R6 R4 empty write loaded", r, ~32'h1234_5678);
  endtask

  task automatic t_core_then_read();
    logic [31:0] r;
    step(1, 32'hA5A5_1234, 0, 0, OFF, 0, r);
    chk("R2 flag after core write", {31'b0, coreFull}, 1);
    step(0, 0, 1, 0, OFF, 0, r);
    chk("R3 full read data", r, 32'hA5A5_1234);
    chk("R5 flag cleared by read", {31'b0, coreFull}, 0);
    step(0, 0, 1, 0, OFF, 0, r);
    chk("R4 empty read pattern", r, ~32'hA5A5_1234);
  endtask

  task automatic t_wrong_offset();
    logic [31:0] r;
    step(1, 32'h1111_2222, 0, 0, OFF, 0, r);
    step(0, 0, 1, 0, 12'h088, 0, r);
    chk("R9 off-target read data", r, 0);
    chk("R9 flag after off-target read", {31'b0, coreFull}, 1);
    step(0, 0, 0, 1, 12'h090, 32'h7777_7777, r);
    chk("R9 err after off-target write", {31'b0, dbgErr}, 0);
    step(0, 0, 1, 0, OFF, 0, r);
    chk("R9 R3 data kept", r, 32'h1111_2222);
  endtask

  task automatic t_collide_read();
    logic [31:0] r;
    step(1, 32'h0000_00AA, 0, 0, OFF, 0, r);
    step(1, 32'h0000_00BB, 1, 0, OFF, 0, r);
    chk("R10 read returns old word", r, 32'h0000_00AA);
    chk("R10 flag stays set", {31'b0, coreFull}, 1);
    step(0, 0, 1, 0, OFF, 0, r);
    chk("R10 new word kept", r, 32'h0000_00BB);
  endtask

  task automatic t_collide_write();
    logic [31:0] r;
    step(1, 32'hCCCC_0001, 0, 1, OFF, 32'h0000_0099, r);
    chk("R11 flag set by core", {31'b0, coreFull}, 1);
    chk("R11 no error when was empty", {31'b0, dbgErr}, 0);
    step(0, 0, 1, 0, OFF, 0, r);
    chk("R11 core word wins", r, 32'hCCCC_0001);
  endtask

  task automatic t_corrupt();
    logic [31:0] r;
    step(1, 32'h0000_0055, 0, 0, OFF, 0, r);
    step(0, 0, 0, 1, OFF, 32'h0000_0077, r);
    chk("R8 flag kept on full write", {31'b0, coreFull}, 1);
    chk("R7 error set", {31'b0, dbgErr}, 1);
    step(0, 0, 1, 0, OFF, 0, r);
    chk("R7 corruption pattern", r, CORRUPT);
    step(1, 32'h0000_0066, 0, 0, OFF, 0, r);
    step(0, 0, 1, 0, OFF, 0, r);
    chk("R12 error persists", {31'b0, dbgErr}, 1);
    chk("R3 read after corruption", r, 32'h0000_0066);
    doReset();
    chk("R1 error cleared by reset", {31'b0, dbgErr}, 0);
    step(0, 0, 1, 0, OFF, 0, r);
    chk("R1 data cleared by reset", r, 32'hFFFF_FFFF);
  endtask

  initial begin
    t_reset();
    t_dbg_write_empty();
    t_core_then_read();
    t_wrong_offset();
    t_collide_read();
    t_collide_write();
    t_corrupt();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule